// File: doc/BRIEF.md
# Bidirectional Mailbox Register Pair

This block carries single command words between two independently clocked ports. Each direction has its own register. Port A deposits words into mailbox 1, and port B collects them. Port B deposits words into mailbox 2, and port A collects them. Each mailbox has an active-low occupancy flag. The flag drops when a word is accepted and rises again once the far side has collected the word. While the flag is low, the sending side cannot overwrite the register.

The flag is owned by the writer's clock domain. The write event reaches the reader through a toggle and a two-stage synchronizer. The reader's acknowledge returns the same way. As a result, the reader can only take a word whose data has been stable for at least two of its own clock edges.

On port B, the read path also selects between mailbox 1 and a FIFO output word supplied from outside the block. The two ports encode their direction select with opposite polarity.

Top module: `mbx_pair`

## Requirements
- R1: An access on a port happens only on a rising clock edge where that port's chip select is low (0) and its enable is high (1). On port A the direction select is high (1) for a write and low (0) for a read. On port B the direction select is low (0) for a write and high (1) for a read. The mailbox select must be high (1) for the access to reach a mailbox.
- R2: An accepted write on port A stores `a_din` into mailbox 1 and drives `mbf1_n` low right after that edge. An accepted write on port B does the same for mailbox 2 with `b_din` and `mbf2_n`.
- R3: A write to a mailbox whose flag is low is ignored, and the stored word is kept.
- R4: A read on the receiving port, at the third or a later receiving-clock edge after the accepted write, collects the mail. The flag then goes high after the second writer-clock edge that follows the read edge. A new write is accepted from the next edge onward.
- R5: A receiving-port mailbox read has no effect when no synchronized pending mail exists. This covers a read at the first or second edge after the write, and a repeated read while an acknowledge is still in flight.
- R6: Reading a mailbox never changes its contents.
- R7: `b_oe` is high exactly when `b_cs_n` is 0 and `b_dir` is 1. `b_dout` presents mailbox 1 when `b_mbsel` is 1 and `fifo_word` when `b_mbsel` is 0.
- R8: `a_oe` is high exactly when `a_cs_n` is 0 and `a_dir` is 0. `a_dout` always presents mailbox 2.
- R9: A synchronous active-high reset (`rst_a` on port A, `rst_b` on port B) sets both flags high and clears both mailboxes to zero.
- R10: With enable low, no write or read takes effect, whatever the other controls are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_dir | input | 1 | Port A direction: 1 write, 0 read |
| a_en | input | 1 | Port A enable |
| a_mbsel | input | 1 | Port A mailbox select |
| a_din | input | DW | Port A write data |
| a_dout | output | DW | Port A read data (mailbox 2) |
| a_oe | output | 1 | Port A output drive enable |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_dir | input | 1 | Port B direction: 0 write, 1 read |
| b_en | input | 1 | Port B enable |
| b_mbsel | input | 1 | Port B mailbox select |
| b_din | input | DW | Port B write data |
| fifo_word | input | DW | FIFO output word from outside |
| b_dout | output | DW | Port B read data |
| b_oe | output | 1 | Port B output drive enable |
| mbf1_n | output | 1 | Mailbox 1 flag, low while mail is pending |
| mbf2_n | output | 1 | Mailbox 2 flag, low while mail is pending |

## Verification
The bench runs both port clocks coincident, so every latency is a fixed edge count. A flag falls right after the writing edge. A read first counts at the third receiving edge after the write. The flag rises after the second writer edge that follows the accepted read. The read paths are combinational from the present controls and stored words.

A bench model advances on each rising edge and applies these counts. Inputs change and outputs are compared on the falling edge, so each result is checked in the cycle it becomes due. The model also covers early reads and refused writes.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned MBX_DW     = 36;
    localparam int unsigned MBX_STAGES = 2;

    typedef struct packed {
        logic cs_n;
        logic dir;
        logic en;
        logic mbsel;
    } port_ctrl_t;

    // selected: chip select low and enable high on this edge
    function automatic logic port_sel(input port_ctrl_t c);
        return !c.cs_n && c.en;
    endfunction

    // write_level is the dir value meaning "write" on this port
    function automatic logic mbx_write(input port_ctrl_t c, input logic write_level);
        return port_sel(c) && (c.dir == write_level) && c.mbsel;
    endfunction

    function automatic logic mbx_read(input port_ctrl_t c, input logic write_level);
        return port_sel(c) && (c.dir != write_level) && c.mbsel;
    endfunction

    // output drive does not need enable
    function automatic logic port_drive(input port_ctrl_t c, input logic write_level);
        return !c.cs_n && (c.dir != write_level);
    endfunction

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[g] <= '0;
                else if (g == 0)
                    chain[g] <= d;
                else
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
    parameter int unsigned DW     = mbx_pkg::MBX_DW,
    parameter int unsigned STAGES = mbx_pkg::MBX_STAGES
) (
    input  logic          clk_w,
    input  logic          rst_w,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    output logic          flag_n,
    output logic [DW-1:0] mail_q,
    input  logic          clk_r,
    input  logic          rst_r,
    input  logic          rd_req
);
    logic wr_tgl;
    logic ack_sync;
    logic ack_tgl;
    logic wr_seen;
    logic wr_ok;
    logic pend_r;
    logic rd_ok;

    // writer domain
    assign flag_n = (wr_tgl == ack_sync);
    assign wr_ok  = wr_req && flag_n;

    always_ff @(posedge clk_w) begin
        if (rst_w) begin
            wr_tgl <= 1'b0;
            mail_q <= '0;
        end else if (wr_ok) begin
            wr_tgl <= ~wr_tgl;
            mail_q <= wr_data;
        end
    end

    mbx_sync #(.STAGES(STAGES), .WIDTH(1)) u_ack_sync (
        .clk (clk_w),
        .rst (rst_w),
        .d   (ack_tgl),
        .q   (ack_sync)
    );

    // reader domain
    mbx_sync #(.STAGES(STAGES), .WIDTH(1)) u_wr_sync (
        .clk (clk_r),
        .rst (rst_r),
        .d   (wr_tgl),
        .q   (wr_seen)
    );

    assign pend_r = (wr_seen != ack_tgl);
    assign rd_ok  = rd_req && pend_r;

    always_ff @(posedge clk_r) begin
        if (rst_r)
            ack_tgl <= 1'b0;
        else if (rd_ok)
            ack_tgl <= ~ack_tgl;
    end

    // R2: an accepted write leaves the flag low
    p_write_clears_flag_r2: assert property (@(posedge clk_w) disable iff (rst_w)
        wr_ok |=> !flag_n);

    // R3: a write met by a low flag leaves the word alone
    p_refused_write_r3: assert property (@(posedge clk_w) disable iff (rst_w)
        (wr_req && !flag_n) |=> $stable(mail_q));

    // R6: the word moves only on an accepted write
    p_word_held_r6: assert property (@(posedge clk_w) disable iff (rst_w)
        !wr_ok |=> $stable(mail_q));

    // R5: a read with nothing synchronized produces no acknowledge
    p_idle_read_r5: assert property (@(posedge clk_r) disable iff (rst_r)
        (rd_req && !pend_r) |=> $stable(ack_tgl));

    // R4: the flag rises only when a returned acknowledge arrives
    p_flag_rise_r4: assert property (@(posedge clk_w) disable iff (rst_w)
        $rose(flag_n) |-> (ack_sync != $past(ack_sync)));
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
    import mbx_pkg::*;
#(
    parameter int unsigned DW     = MBX_DW,
    parameter int unsigned STAGES = MBX_STAGES
) (
    input  logic          clk_a,
    input  logic          rst_a,
    input  logic          a_cs_n,
    input  logic          a_dir,
    input  logic          a_en,
    input  logic          a_mbsel,
    input  logic [DW-1:0] a_din,
    output logic [DW-1:0] a_dout,
    output logic          a_oe,
    input  logic          clk_b,
    input  logic          rst_b,
    input  logic          b_cs_n,
    input  logic          b_dir,
    input  logic          b_en,
    input  logic          b_mbsel,
    input  logic [DW-1:0] b_din,
    input  logic [DW-1:0] fifo_word,
    output logic [DW-1:0] b_dout,
    output logic          b_oe,
    output logic          mbf1_n,
    output logic          mbf2_n
);
    localparam logic A_WR_LEVEL = 1'b1;
    localparam logic B_WR_LEVEL = 1'b0;

    port_ctrl_t ctl_a, ctl_b;
    logic [DW-1:0] mail1, mail2;

    assign ctl_a = '{cs_n: a_cs_n, dir: a_dir, en: a_en, mbsel: a_mbsel};
    assign ctl_b = '{cs_n: b_cs_n, dir: b_dir, en: b_en, mbsel: b_mbsel};

    mbx_channel #(.DW(DW), .STAGES(STAGES)) u_mbx1 (
        .clk_w   (clk_a),
        .rst_w   (rst_a),
        .wr_req  (mbx_write(ctl_a, A_WR_LEVEL)),
        .wr_data (a_din),
        .flag_n  (mbf1_n),
        .mail_q  (mail1),
        .clk_r   (clk_b),
        .rst_r   (rst_b),
        .rd_req  (mbx_read(ctl_b, B_WR_LEVEL))
    );

    mbx_channel #(.DW(DW), .STAGES(STAGES)) u_mbx2 (
        .clk_w   (clk_b),
        .rst_w   (rst_b),
        .wr_req  (mbx_write(ctl_b, B_WR_LEVEL)),
        .wr_data (b_din),
        .flag_n  (mbf2_n),
        .mail_q  (mail2),
        .clk_r   (clk_a),
        .rst_r   (rst_a),
        .rd_req  (mbx_read(ctl_a, A_WR_LEVEL))
    );

    assign a_oe   = port_drive(ctl_a, A_WR_LEVEL);
    assign a_dout = mail2;
    assign b_oe   = port_drive(ctl_b, B_WR_LEVEL);
    assign b_dout = b_mbsel ? mail1 : fifo_word;

    // R7: with mailbox select low the driven word is the FIFO word
    p_bpath_fifo_r7: assert property (@(posedge clk_b) disable iff (rst_b)
        (b_oe && !b_mbsel) |-> (b_dout == fifo_word));

    // R9: the cycle after reset both flags read high
    p_reset_flags_r9: assert property (@(posedge clk_a) disable iff (rst_b)
        $past(rst_a) |-> (mbf1_n && mbf2_n));
endmodule

// File: tb/mbx_pair_test.sv
module mbx_pair_test;
    localparam int DW = 36;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_cs_n = 1'b1, a_dir = 1'b0, a_en = 1'b0, a_mbsel = 1'b0;
    logic b_cs_n = 1'b1, b_dir = 1'b1, b_en = 1'b0, b_mbsel = 1'b0;
    logic [DW-1:0] a_din = '0, b_din = '0, fifo_word = '0;
    logic [DW-1:0] a_dout, b_dout;
    logic a_oe, b_oe, mbf1_n, mbf2_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    mbx_pair uut (
        .clk_a(clk), .rst_a(rst), .a_cs_n(a_cs_n), .a_dir(a_dir), .a_en(a_en),
        .a_mbsel(a_mbsel), .a_din(a_din), .a_dout(a_dout), .a_oe(a_oe),
        .clk_b(clk), .rst_b(rst), .b_cs_n(b_cs_n), .b_dir(b_dir), .b_en(b_en),
        .b_mbsel(b_mbsel), .b_din(b_din), .fifo_word(fifo_word),
        .b_dout(b_dout), .b_oe(b_oe), .mbf1_n(mbf1_n), .mbf2_n(mbf2_n)
    );

    // reference model: index 0 = mailbox 1 (A->B), 1 = mailbox 2 (B->A)
    int cyc = 0;
    bit m_low [2];
    int m_w   [2];
    int m_rd  [2];
    logic [DW-1:0] m_data [2];

    function automatic bit wreq(input int i);
        if (i == 0) return !a_cs_n && a_en && a_dir && a_mbsel;
        return !b_cs_n && b_en && !b_dir && b_mbsel;
    endfunction

    function automatic bit rreq(input int i);
        if (i == 0) return !b_cs_n && b_en && b_dir && b_mbsel;
        return !a_cs_n && a_en && !a_dir && a_mbsel;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 2; i++) begin
                m_low[i] = 1'b0; m_w[i] = 0; m_rd[i] = -1; m_data[i] = '0;
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                bit pre, acc_w, acc_r;
                pre   = m_low[i];
                acc_w = wreq(i) && !pre;
                acc_r = rreq(i) && pre && (m_rd[i] < 0) && (cyc >= m_w[i] + 3);
                if (m_rd[i] >= 0 && cyc == m_rd[i] + 2) begin
                    m_low[i] = 1'b0;
                    m_rd[i]  = -1;
                end
                if (acc_w) begin
                    m_low[i]  = 1'b1;
                    m_w[i]    = cyc;
                    m_data[i] = (i == 0) ? a_din : b_din;
                end
                if (acc_r) m_rd[i] = cyc;
            end
        end
        cyc++;
    end

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R2 R4 R5 mbf1_n", DW'(mbf1_n), DW'(!m_low[0]));
        chk("R2 R4 R5 mbf2_n", DW'(mbf2_n), DW'(!m_low[1]));
        chk("R8 a_oe", DW'(a_oe), DW'(!a_cs_n && !a_dir));
        chk("R3 R6 R8 a_dout", a_dout, m_data[1]);
        chk("R7 b_oe", DW'(b_oe), DW'(!b_cs_n && b_dir));
        chk("R1 R3 R6 R7 b_dout", b_dout, b_mbsel ? m_data[0] : fifo_word);
    endtask

    task automatic idle();
        a_cs_n = 1'b1; a_en = 1'b0; b_cs_n = 1'b1; b_en = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    function automatic logic [DW-1:0] rnd_word();
        logic [63:0] t;
        t = {$urandom(), $urandom()};
        return t[DW-1:0];
    endfunction

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        chk("R9 mbf1_n after reset", DW'(mbf1_n), DW'(1'b1));
        chk("R9 mbf2_n after reset", DW'(mbf2_n), DW'(1'b1));
        chk("R9 mailbox 2 cleared", a_dout, '0);

        // R10: enable low, write attempt ignored
        a_cs_n = 1'b0; a_dir = 1'b1; a_mbsel = 1'b1; a_en = 1'b0; a_din = 36'h123456789;
        tick();
        chk("R10 no write without enable", DW'(mbf1_n), DW'(1'b1));

        // R2: accepted write on A
        a_en = 1'b1;
        tick();
        chk("R2 flag low after write", DW'(mbf1_n), DW'(1'b0));
        // R3: second write refused
        a_din = 36'hABCDEF012;
        tick();
        idle();
        // R5: read from B on an early edge (edge 2 after write)
        b_cs_n = 1'b0; b_en = 1'b1; b_dir = 1'b1; b_mbsel = 1'b1;
        tick();
        b_en = 1'b0;
        tick(); tick(); tick();
        chk("R5 early read ignored", DW'(mbf1_n), DW'(1'b0));
        chk("R3 first word kept", b_dout, 36'h123456789);
        // R4: proper read, flag returns
        b_en = 1'b1;
        tick();
        b_en = 1'b0;
        tick(); tick();
        chk("R4 flag high after ack", DW'(mbf1_n), DW'(1'b1));
        chk("R6 word unchanged by read", b_dout, 36'h123456789);
        idle();
        tick();

        // random phase
        for (int n = 0; n < 4000; n++) begin
            a_cs_n  = ($urandom_range(0, 9) < 3);
            a_en    = ($urandom_range(0, 9) < 8);
            a_dir   = $urandom_range(0, 1);
            a_mbsel = ($urandom_range(0, 9) < 7);
            a_din   = rnd_word();
            b_cs_n  = ($urandom_range(0, 9) < 3);
            b_en    = ($urandom_range(0, 9) < 8);
            b_dir   = $urandom_range(0, 1);
            b_mbsel = ($urandom_range(0, 9) < 7);
            b_din   = rnd_word();
            fifo_word = rnd_word();
            tick();
        end
        idle();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired: actual hung, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule